// File: doc/BRIEF.md
# Bit-Vector Coherence Directory Controller

This block is the home-side directory for an invalidation-based coherence scheme spread across up to sixteen clusters. Each memory line owned by this home has one directory entry. The entry holds a presence vector with one bit per cluster and one state bit that says how to read the vector: marked clusters either hold clean copies, or exactly one of them holds a modified copy. An entry whose vector is all zero is an uncached line.

Each time the local bus carries a coherence request, the block looks up the entry for the addressed line. It combines that entry with the request kind, the requesting cluster and the local snoop outcome. From these it decides which network message to emit: a data reply to the requester, a forward to the dirty owner, or invalidations to the other sharers. It also decides whether the requesting processor must be told to retry. The updated entry is written back in the same cycle. A retry also sets that processor's bit in a hold mask, and the bit stays set until the remote reply for that processor comes back.

Top module: `coh_directory`

## Requirements
- R1: After reset every line is uncached, `rspValid` and `retry` are low and `holdMask` is zero.
- R2: A read (reqType 0) with no snoop hit to an uncached or shared line gives rspMsg 1 (reply) with rspDest holding only the requester's bit. The requester's bit is added to the vector and the state stays shared. rspEntry is {state bit, vector}, with bit NCLUST set meaning dirty.
- R3: A read to a dirty line gives rspMsg 2 (forward) with rspDest equal to the owner's bit, and raises retry. The new entry is shared with the owner and requester bits set.
- R4: A read-exclusive (reqType 1) to an uncached line gives a reply to the requester. The new entry is dirty with only the requester's bit set.
- R5: A read-exclusive to a shared line gives rspMsg 3 (invalidate) to every marked cluster except the requester, and raises retry. If no other cluster is marked, a plain reply is given with no retry. In both cases the new entry is dirty with only the requester's bit.
- R6: A read-exclusive to a line that another cluster holds dirty gives a forward to that owner with retry, and the requester becomes the sole dirty holder. If the requester already owns the line, a plain reply is given with no retry.
- R7: A write-back (reqType 2) clears the entry to uncached and reports rspMsg 0 (none) with an empty rspDest.
- R8: A read with snoopHit set is satisfied inside the cluster. It reports rspMsg 0, leaves the entry unchanged and raises no retry.
- R9: reqType 3 is ignored. No strobe follows and the line's entry is unchanged.
- R10: The response strobe is one cycle wide and appears in the cycle after the request is accepted. Back-to-back requests to the same line see the previous update.
- R11: A retry sets holdMask bit reqProc, and replyDone clears holdMask bit replyProc. If both target the same bit in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus request present this cycle |
| reqType | input | 2 | 0 read, 1 read-exclusive, 2 write-back, 3 reserved |
| reqAddr | input | ADDR_W | Line index |
| reqCluster | input | CID_W | Requesting cluster |
| reqProc | input | PID_W | Local processor that issued the bus request |
| snoopHit | input | 1 | Local cache-to-cache transfer satisfied the request |
| replyDone | input | 1 | A remote reply arrived for replyProc |
| replyProc | input | PID_W | Processor whose remote reply arrived |
| rspValid | output | 1 | One-cycle response strobe |
| rspMsg | output | 2 | 0 none, 1 reply, 2 forward, 3 invalidate |
| rspDest | output | NCLUST | Destination cluster mask |
| rspEntry | output | NCLUST+1 | Updated entry {dirty bit, presence vector} |
| retry | output | 1 | Requesting processor must retry |
| holdMask | output | NPROC | Processors whose retry is held off |

## Verification
Two functions can land on the same hold-mask bit in the same cycle: a new request that needs remote service sets the bit for its processor, and a returning remote reply clears the bit for its processor. A directed case drives a forwarded request and a reply for the same processor together, and expects the bit to stay set. A second case drives them for different processors, and expects one bit to rise and the other to fall. Random traffic also asserts replies freely alongside requests. After every edge the mask is compared with a bench model that applies the clear first and the set second.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    MSG_NONE  = 2'd0,
    MSG_REPLY = 2'd1,
    MSG_FWD   = 2'd2,
    MSG_INVAL = 2'd3
  } msg_e;

  typedef enum logic [1:0] {
    REQ_READ   = 2'd0,
    REQ_READEX = 2'd1,
    REQ_WBACK  = 2'd2,
    REQ_RSVD   = 2'd3
  } req_e;

  // how the datapath forms the next presence vector
  typedef enum logic [1:0] {
    VEC_KEEP  = 2'd0,
    VEC_ADD   = 2'd1,
    VEC_SOLE  = 2'd2,
    VEC_CLEAR = 2'd3
  } vecOp_e;

  // which mask the datapath sends out as destination
  typedef enum logic [1:0] {
    DST_NONE   = 2'd0,
    DST_REQ    = 2'd1,
    DST_OWNER  = 2'd2,
    DST_OTHERS = 2'd3
  } dstSel_e;

  typedef struct packed {
    logic    isDirty;
    logic    isEmpty;
    logic    reqIsSole;
    logic    othersSet;
  } entryStat_s;

  typedef struct packed {
    logic    wrEn;
    logic    outEn;
    logic    setHold;
    logic    nextDirty;
    msg_e    msg;
    vecOp_e  vecOp;
    dstSel_e dstSel;
  } dirCtrl_s;

endpackage

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
(
  input  logic       reqValid,
  input  logic [1:0] reqType,
  input  logic       snoopHit,
  input  entryStat_s stat,
  output dirCtrl_s   ctrl
);

  req_e kind;
  assign kind = req_e'(reqType);

  always_comb begin
    ctrl = '{wrEn: 1'b0, outEn: 1'b0, setHold: 1'b0, nextDirty: stat.isDirty,
             msg: MSG_NONE, vecOp: VEC_KEEP, dstSel: DST_NONE};
    if (reqValid) begin
      unique case (kind)
        REQ_READ: begin
          ctrl.outEn = 1'b1;
          if (!snoopHit) begin
            ctrl.wrEn      = 1'b1;
            ctrl.vecOp     = VEC_ADD;
            ctrl.nextDirty = 1'b0;
            if (stat.isDirty) begin
              ctrl.msg     = MSG_FWD;
              ctrl.dstSel  = DST_OWNER;
              ctrl.setHold = 1'b1;
            end else begin
              ctrl.msg    = MSG_REPLY;
              ctrl.dstSel = DST_REQ;
            end
          end
        end
        REQ_READEX: begin
          ctrl.outEn     = 1'b1;
          ctrl.wrEn      = 1'b1;
          ctrl.vecOp     = VEC_SOLE;
          ctrl.nextDirty = 1'b1;
          if (stat.isDirty && !stat.reqIsSole) begin
            ctrl.msg     = MSG_FWD;
            ctrl.dstSel  = DST_OWNER;
            ctrl.setHold = 1'b1;
          end else if (!stat.isDirty && stat.othersSet) begin
            ctrl.msg     = MSG_INVAL;
            ctrl.dstSel  = DST_OTHERS;
            ctrl.setHold = 1'b1;
          end else begin
            ctrl.msg    = MSG_REPLY;
            ctrl.dstSel = DST_REQ;
          end
        end
        REQ_WBACK: begin
          ctrl.outEn     = 1'b1;
          ctrl.wrEn      = 1'b1;
          ctrl.vecOp     = VEC_CLEAR;
          ctrl.nextDirty = 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/coh_dir_datapath.sv
module coh_dir_datapath
  import coh_dir_pkg::*;
#(
  parameter int NCLUST = 16,
  parameter int LINES  = 64,
  parameter int NPROC  = 4,
  localparam int ADDR_W = $clog2(LINES),
  localparam int CID_W  = $clog2(NCLUST),
  localparam int PID_W  = $clog2(NPROC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CID_W-1:0]  reqCluster,
  input  logic [PID_W-1:0]  reqProc,
  input  logic              replyDone,
  input  logic [PID_W-1:0]  replyProc,
  input  dirCtrl_s          ctrl,
  output entryStat_s        stat,
  output logic              rspValid,
  output logic [1:0]        rspMsg,
  output logic [NCLUST-1:0] rspDest,
  output logic [NCLUST:0]   rspEntry,
  output logic              retry,
  output logic [NPROC-1:0]  holdMask
);

  logic [NCLUST-1:0] vecMem [LINES];
  logic              dirtyMem [LINES];

  logic [NCLUST-1:0] reqBit, curVec, otherVec, nextVec, destVal;
  logic              curDirty;

  assign reqBit   = NCLUST'(1) << reqCluster;
  assign curVec   = vecMem[reqAddr];
  assign curDirty = dirtyMem[reqAddr];
  assign otherVec = curVec & ~reqBit;

  assign stat.isDirty   = curDirty;
  assign stat.isEmpty   = (curVec == '0);
  assign stat.reqIsSole = (curVec == reqBit);
  assign stat.othersSet = (otherVec != '0);

  always_comb begin
    unique case (ctrl.vecOp)
      VEC_ADD:   nextVec = curVec | reqBit;
      VEC_SOLE:  nextVec = reqBit;
      VEC_CLEAR: nextVec = '0;
      default:   nextVec = curVec;
    endcase
    unique case (ctrl.dstSel)
      DST_REQ:    destVal = reqBit;
      DST_OWNER:  destVal = curVec;
      DST_OTHERS: destVal = otherVec;
      default:    destVal = '0;
    endcase
  end

  // entry storage, written in the lookup cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        vecMem[i]   <= '0;
        dirtyMem[i] <= 1'b0;
      end
    end else if (ctrl.wrEn) begin
      vecMem[reqAddr]   <= nextVec;
      dirtyMem[reqAddr] <= ctrl.nextDirty;
    end
  end

  // response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      retry    <= 1'b0;
      rspMsg   <= MSG_NONE;
      rspDest  <= '0;
      rspEntry <= '0;
    end else begin
      rspValid <= ctrl.outEn;
      retry    <= ctrl.outEn && ctrl.setHold;
      if (ctrl.outEn) begin
        rspMsg   <= ctrl.msg;
        rspDest  <= destVal;
        rspEntry <= {ctrl.nextDirty, nextVec};
      end
    end
  end

  // hold mask: per-processor set/clear, set has priority
  logic [NPROC-1:0] setVec, clrVec;
  for (genvar p = 0; p < NPROC; p++) begin : g_hold
    assign setVec[p] = ctrl.outEn && ctrl.setHold && (reqProc == PID_W'(p));
    assign clrVec[p] = replyDone && (replyProc == PID_W'(p));
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdMask <= '0;
    else       holdMask <= (holdMask & ~clrVec) | setVec;
  end

endmodule

// File: rtl/coh_directory.sv
module coh_directory
  import coh_dir_pkg::*;
#(
  parameter int NCLUST = 16,
  parameter int LINES  = 64,
  parameter int NPROC  = 4,
  localparam int ADDR_W = $clog2(LINES),
  localparam int CID_W  = $clog2(NCLUST),
  localparam int PID_W  = $clog2(NPROC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CID_W-1:0]  reqCluster,
  input  logic [PID_W-1:0]  reqProc,
  input  logic              snoopHit,
  input  logic              replyDone,
  input  logic [PID_W-1:0]  replyProc,
  output logic              rspValid,
  output logic [1:0]        rspMsg,
  output logic [NCLUST-1:0] rspDest,
  output logic [NCLUST:0]   rspEntry,
  output logic              retry,
  output logic [NPROC-1:0]  holdMask
);

  entryStat_s stat;
  dirCtrl_s   ctrl;

  coh_dir_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqType  (reqType),
    .snoopHit (snoopHit),
    .stat     (stat),
    .ctrl     (ctrl)
  );

  coh_dir_datapath #(.NCLUST(NCLUST), .LINES(LINES), .NPROC(NPROC)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqAddr    (reqAddr),
    .reqCluster (reqCluster),
    .reqProc    (reqProc),
    .replyDone  (replyDone),
    .replyProc  (replyProc),
    .ctrl       (ctrl),
    .stat       (stat),
    .rspValid   (rspValid),
    .rspMsg     (rspMsg),
    .rspDest    (rspDest),
    .rspEntry   (rspEntry),
    .retry      (retry),
    .holdMask   (holdMask)
  );

endmodule

// File: rtl/coh_directory_chk.sv
module coh_directory_chk #(
  parameter int NCLUST = 16,
  parameter int NPROC  = 4,
  parameter int CID_W  = 4,
  parameter int PID_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqType,
  input logic [CID_W-1:0]  reqCluster,
  input logic [PID_W-1:0]  reqProc,
  input logic              rspValid,
  input logic [1:0]        rspMsg,
  input logic [NCLUST-1:0] rspDest,
  input logic [NCLUST:0]   rspEntry,
  input logic              retry,
  input logic [NPROC-1:0]  holdMask
);

  // R10: a strobe only follows an accepted, non-reserved request
  a_r10_strobe_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(reqValid) && $past(reqType) != 2'd3));

  // R9: reserved kind produces no strobe
  a_r9_reserved_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqType == 2'd3) |=> !rspValid);

  // R5: invalidations never target the requester and are never empty
  a_r5_inval_excludes_req: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMsg == 2'd3) |-> (rspDest[$past(reqCluster)] == 1'b0 && rspDest != '0));

  // R6: a dirty entry names exactly one owner
  a_r6_dirty_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspEntry[NCLUST]) |-> ($countones(rspEntry[NCLUST-1:0]) == 1));

  // R3: retry only with remote service messages
  a_r3_retry_remote_only: assert property (@(posedge clk) disable iff (!rstN)
    retry |-> (rspValid && (rspMsg == 2'd2 || rspMsg == 2'd3)));

  // R11: a retried processor is held
  a_r11_retry_sets_hold: assert property (@(posedge clk) disable iff (!rstN)
    retry |-> holdMask[$past(reqProc)]);

  // R7: write-back leaves the line uncached
  a_r7_wback_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqType) == 2'd2) |-> (rspEntry == '0 && rspMsg == 2'd0));

endmodule

bind coh_directory coh_directory_chk #(
  .NCLUST(NCLUST), .NPROC(NPROC), .CID_W(CID_W), .PID_W(PID_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
  .reqCluster(reqCluster), .reqProc(reqProc), .rspValid(rspValid),
  .rspMsg(rspMsg), .rspDest(rspDest), .rspEntry(rspEntry),
  .retry(retry), .holdMask(holdMask)
);

// File: tb/tb_coh_directory.sv
module tb_coh_directory;

  localparam int NCLUST = 16;
  localparam int LINES  = 64;
  localparam int NPROC  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqType = '0;
  logic [5:0]  reqAddr = '0;
  logic [3:0]  reqCluster = '0;
  logic [1:0]  reqProc = '0;
  logic        snoopHit = 1'b0;
  logic        replyDone = 1'b0;
  logic [1:0]  replyProc = '0;
  logic        rspValid;
  logic [1:0]  rspMsg;
  logic [15:0] rspDest;
  logic [16:0] rspEntry;
  logic        retry;
  logic [3:0]  holdMask;

  always #2 clk = ~clk;

  coh_directory dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .reqCluster(reqCluster), .reqProc(reqProc),
    .snoopHit(snoopHit), .replyDone(replyDone), .replyProc(replyProc),
    .rspValid(rspValid), .rspMsg(rspMsg), .rspDest(rspDest),
    .rspEntry(rspEntry), .retry(retry), .holdMask(holdMask)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit [15:0] mVec [LINES];
  bit        mDirty [LINES];
  bit [3:0]  mHold;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle of stimulus, advance one edge, compare with model
  task automatic issue(bit vld, bit [1:0] typ, bit [5:0] a, bit [3:0] cl, bit [1:0] pr,
                       bit snp, bit rd, bit [1:0] rp, string tag);
    bit [15:0] rb, cv, nv, eDest;
    bit        cd, nd, eValid, eRetry;
    bit [1:0]  eMsg;
    rb = 16'(1) << cl;
    cv = mVec[a]; cd = mDirty[a];
    nv = cv; nd = cd; eValid = 1'b0; eRetry = 1'b0; eMsg = 2'd0; eDest = '0;
    if (vld) begin
      case (typ)
        2'd0: begin
          eValid = 1'b1;
          if (!snp) begin
            nv = cv | rb; nd = 1'b0;
            if (cd) begin eMsg = 2'd2; eDest = cv; eRetry = 1'b1; end
            else    begin eMsg = 2'd1; eDest = rb; end
          end
        end
        2'd1: begin
          eValid = 1'b1; nv = rb; nd = 1'b1;
          if (cd && cv != rb)              begin eMsg = 2'd2; eDest = cv; eRetry = 1'b1; end
          else if (!cd && (cv & ~rb) != 0) begin eMsg = 2'd3; eDest = cv & ~rb; eRetry = 1'b1; end
          else                             begin eMsg = 2'd1; eDest = rb; end
        end
        2'd2: begin eValid = 1'b1; nv = '0; nd = 1'b0; end
        default: ;
      endcase
    end
    mVec[a] = nv; mDirty[a] = nd;
    if (rd) mHold[rp] = 1'b0;
    if (eRetry) mHold[pr] = 1'b1;

    reqValid = vld; reqType = typ; reqAddr = a; reqCluster = cl; reqProc = pr;
    snoopHit = snp; replyDone = rd; replyProc = rp;
    @(negedge clk);
    reqValid = 1'b0; replyDone = 1'b0;
    chk(tag, "valid", 32'(rspValid), 32'(eValid));
    if (eValid) begin
      chk(tag, "msg",   32'(rspMsg),   32'(eMsg));
      chk(tag, "dest",  32'(rspDest),  32'(eDest));
      chk(tag, "entry", 32'(rspEntry), 32'({nd, nv}));
    end
    chk(tag, "retry", 32'(retry), 32'(eRetry));
    chk(tag, "hold",  32'(holdMask), 32'(mHold));
  endtask

  task automatic rq(bit [1:0] typ, bit [5:0] a, bit [3:0] cl, bit [1:0] pr, string tag);
    issue(1'b1, typ, a, cl, pr, 1'b0, 1'b0, 2'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < LINES; i++) begin mVec[i] = '0; mDirty[i] = 1'b0; end
    mHold = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "valid", 32'(rspValid), 0);
    chk("R1", "retry", 32'(retry), 0);
    chk("R1", "hold",  32'(holdMask), 0);

    // R1 R2: read to fresh line proves it was uncached; then a second sharer
    rq(2'd0, 6'd5, 4'd3, 2'd0, "R2");
    rq(2'd0, 6'd5, 4'd9, 2'd1, "R2");
    // R10: strobe one cycle wide
    @(negedge clk);
    chk("R10", "strobe width", 32'(rspValid), 0);
    // R5: read-exclusive to shared line invalidates others
    rq(2'd1, 6'd5, 4'd3, 2'd2, "R5");
    // R3: read to dirty line forwards to owner
    rq(2'd0, 6'd5, 4'd7, 2'd1, "R3");
    // R5: read-exclusive where requester is the only sharer
    rq(2'd0, 6'd6, 4'd2, 2'd0, "R5");
    rq(2'd1, 6'd6, 4'd2, 2'd0, "R5");
    // R6: own dirty line, then another cluster takes it (back-to-back, R10)
    rq(2'd1, 6'd6, 4'd2, 2'd0, "R6");
    rq(2'd1, 6'd6, 4'd11, 2'd3, "R6");
    // R4: read-exclusive to uncached line
    rq(2'd1, 6'd8, 4'd15, 2'd0, "R4");
    // R7: write-back clears
    rq(2'd2, 6'd8, 4'd15, 2'd0, "R7");
    rq(2'd0, 6'd8, 4'd1, 2'd0, "R7");
    // R8: snoop hit on a dirty line leaves entry alone
    issue(1'b1, 2'd0, 6'd6, 4'd4, 2'd2, 1'b1, 1'b0, 2'd0, "R8");
    rq(2'd0, 6'd6, 4'd4, 2'd2, "R8");
    // R9: reserved kind ignored, then read proves entry unchanged
    issue(1'b1, 2'd3, 6'd8, 4'd6, 2'd0, 1'b0, 1'b0, 2'd0, "R9");
    rq(2'd0, 6'd8, 4'd6, 2'd0, "R9");
    // R11: set and clear on the same bit in one cycle -> set wins
    rq(2'd1, 6'd9, 4'd5, 2'd0, "R11");
    issue(1'b1, 2'd0, 6'd9, 4'd8, 2'd1, 1'b0, 1'b1, 2'd1, "R11");
    // R11: set one bit while clearing another
    rq(2'd1, 6'd10, 4'd5, 2'd0, "R11");
    issue(1'b1, 2'd1, 6'd10, 4'd12, 2'd2, 1'b0, 1'b1, 2'd3, "R11");
    issue(1'b0, 2'd0, 6'd0, 4'd0, 2'd0, 1'b0, 1'b1, 2'd1, "R11");

    // random traffic over a few lines
    for (int n = 0; n < 3000; n++) begin
      bit [1:0] t;
      t = 2'($urandom_range(0, 3));
      if (t == 2'd3 && $urandom_range(0, 3) != 0) t = 2'd0;
      issue(($urandom_range(0, 5) != 0), t, 6'($urandom_range(0, 7)),
            4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
            2'($urandom_range(0, 3)), "R2-mix");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule